// File: doc/BRIEF.md
# Nametable Source Selector with Fill Mode

This block sits between a video fetch unit and the memories behind the 4 KB nametable window. It splits the window into four 1 KB quadrants. A 2-bit code for each quadrant sends the access to one of four places: page 0 of the external 2 KB nametable RAM, page 1 of that RAM, a 1 KB extended RAM held inside the block, or a constant fill tile byte. Changing the codes gives mirroring layouts such as vertical, horizontal and single-page. It can also show a whole quadrant as a single repeated tile.

A CPU register port sets four things: the quadrant codes, the fill tile, a 2-bit fill attribute, and a 2-bit extended-RAM mode. The extended-RAM mode decides whether video-side writes may reach the extended RAM. The same port reads and writes the extended RAM directly through a 1 KB window. All read data, on both the video side and the CPU side, appears one cycle after the read strobe and holds until the next read on that side. The external nametable RAM must also return its data one cycle after `ntRe`.

Top module: `nametable_router`

## Requirements
- R1: A video access is decoded only when vidAddr[13:12] is 2'b10. Its quadrant is vidAddr[11:10], and the quadrant's source code is map register bits [2q+1:2q].
- R2: For code 0 or 1, a video read raises ntRe and a video write raises ntWe, with ntAddr = {code[0], vidAddr[9:0]} and ntWrData = vidWrData. A read returns ntRdData one cycle later. Neither strobe rises for any other code or for an address outside the window.
- R3: For code 2, a video read returns the extended-RAM byte at vidAddr[9:0] one cycle later.
- R4: For code 2, a video write stores into the extended RAM only while the extended-RAM mode is 0 or 1. With mode 2 or 3 the write is dropped.
- R5: For code 3, a video read returns the fill tile value held in the cycle of the read. A video write to such a quadrant changes no memory.
- R6: CPU writes take effect in the next cycle. The registers are: 0x5104 extended-RAM mode (bits [1:0]), 0x5105 map register (8 bits), 0x5106 fill tile (8 bits), and 0x5107 fill attribute (bits [1:0], shown on fillAttr). A write to any other register address changes nothing.
- R7: The CPU reads and writes the extended RAM at 0x5C00-0x5FFF, using cpuAddr[9:0] as the index. CPU read data appears on cpuRdData one cycle after cpuRd. A read of any other address returns 0.
- R8: After reset the map register is 0x44 (quadrants 0 and 2 on page 0, quadrants 1 and 3 on page 1). The extended-RAM mode, fill tile and fill attribute are 0, and both read data outputs are 0.
- R9: When the CPU writes the extended RAM in a cycle, any video write to the extended RAM in that cycle is dropped. A video read of the extended RAM in that cycle returns the data held before the CPU write.
- R10: vidRdData holds its value until the next vidRd. A video read outside the window returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuWr | input | 1 | CPU write strobe |
| cpuRd | input | 1 | CPU read strobe |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuRdData | output | 8 | CPU read data, one cycle after cpuRd |
| vidRd | input | 1 | Video read strobe |
| vidWr | input | 1 | Video write strobe |
| vidAddr | input | 14 | Video address |
| vidWrData | input | 8 | Video write data |
| vidRdData | output | 8 | Video read data, one cycle after vidRd |
| ntAddr | output | 11 | External nametable RAM address (page bit, offset) |
| ntRe | output | 1 | External nametable RAM read enable |
| ntWe | output | 1 | External nametable RAM write enable |
| ntWrData | output | 8 | External nametable RAM write data |
| ntRdData | input | 8 | External nametable RAM read data, one cycle after ntRe |
| fillAttr | output | 2 | Fill attribute register |

## Verification
Assertions check the following on every cycle:
- the register reset values and register hold behaviour;
- that every CPU write and every accepted video write to the extended RAM lands in the next cycle;
- that a fill-quadrant read returns the fill tile that was current when it was issued;
- that the external RAM strobes and the extended-RAM video write never fire together.

The bench scenarios cover what those checks do not:
- the address decoding for every quadrant code;
- video writes blocked by the extended-RAM mode;
- a video write that arrives in the same cycle as a CPU write to the extended RAM;
- a video read that sees data from before a same-cycle CPU write;
- out-of-window accesses.

A long pseudo-random run, compared against the behavioural model on every clock, covers the combinations of these cases.

// File: rtl/nt_route_pkg.sv
package nt_route_pkg;

  localparam int QUAD_BITS = 2;
  localparam int QUADS     = 1 << QUAD_BITS;
  localparam int CODE_W    = 2;
  localparam int MAP_W     = CODE_W * QUADS;
  localparam int MODE_W    = 2;

  // CPU-visible register addresses (decoded by software, so fixed)
  localparam logic [15:0] REG_EXMODE = 16'h5104;
  localparam logic [15:0] REG_MAP    = 16'h5105;
  localparam logic [15:0] REG_FILL   = 16'h5106;
  localparam logic [15:0] REG_ATTR   = 16'h5107;
  localparam logic [15:0] EX_BASE    = 16'h5C00;

  localparam logic [MAP_W-1:0]  MAP_RESET      = 8'h44;
  localparam logic [MODE_W-1:0] EX_WRITE_LIMIT = 2'd2;

  typedef enum logic [CODE_W-1:0] {
    SRC_PAGE0 = 2'd0,
    SRC_PAGE1 = 2'd1,
    SRC_EXRAM = 2'd2,
    SRC_FILL  = 2'd3
  } ntSrc_t;

  // control -> datapath strobes
  typedef struct packed {
    logic   vidHit;    // video address inside the nametable window
    ntSrc_t vidSrc;    // source picked for the video access
    logic   vidRead;   // video read this cycle
    logic   vidWrite;  // video write this cycle
    logic   vidExWr;   // accepted video write into extended RAM
    logic   cpuExWr;   // CPU write into extended RAM
    logic   cpuExRd;   // CPU address hits the extended RAM window
    logic   cpuRead;   // CPU read this cycle
  } ntStrobe_t;

endpackage

// File: rtl/ntsel_ctrl.sv
module ntsel_ctrl
  import nt_route_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OFF_W   = 10,
  parameter int VADDR_W = 14,
  parameter int CADDR_W = 16,
  parameter int ATTR_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpuWr,
  input  logic               cpuRd,
  input  logic [CADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0]  cpuWrData,
  input  logic               vidRd,
  input  logic               vidWr,
  input  logic [VADDR_W-1:0] vidAddr,
  output ntStrobe_t          strb,
  output logic [DATA_W-1:0]  fillTile,
  output logic [ATTR_W-1:0]  fillAttr
);

  localparam int TAG_W = VADDR_W - OFF_W - QUAD_BITS;
  localparam logic [TAG_W-1:0]   WIN_TAG   = TAG_W'(2);
  localparam logic [CADDR_W-1:0] EX_BASE_W = CADDR_W'(EX_BASE);

  logic [MODE_W-1:0] exMode;
  logic [MAP_W-1:0]  mapReg;
  logic [DATA_W-1:0] fillTileQ;
  logic [ATTR_W-1:0] fillAttrQ;

  logic                 inWin;
  logic [QUAD_BITS-1:0] quad;
  logic [CODE_W-1:0]    quadCode [QUADS];
  logic                 cpuExHit;

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      exMode    <= '0;
      mapReg    <= MAP_RESET;
      fillTileQ <= '0;
      fillAttrQ <= '0;
    end else if (cpuWr) begin
      if (cpuAddr == CADDR_W'(REG_EXMODE)) exMode    <= cpuWrData[MODE_W-1:0];
      if (cpuAddr == CADDR_W'(REG_MAP))    mapReg    <= cpuWrData[MAP_W-1:0];
      if (cpuAddr == CADDR_W'(REG_FILL))   fillTileQ <= cpuWrData;
      if (cpuAddr == CADDR_W'(REG_ATTR))   fillAttrQ <= cpuWrData[ATTR_W-1:0];
    end
  end

  // per-quadrant code fields
  for (genvar q = 0; q < QUADS; q++) begin : g_quad
    assign quadCode[q] = mapReg[CODE_W*q +: CODE_W];
  end

  assign inWin    = (vidAddr[VADDR_W-1 -: TAG_W] == WIN_TAG);
  assign quad     = vidAddr[OFF_W +: QUAD_BITS];
  assign cpuExHit = (cpuAddr[CADDR_W-1:OFF_W] == EX_BASE_W[CADDR_W-1:OFF_W]);

  always_comb begin
    strb          = '0;
    strb.vidHit   = inWin;
    strb.vidSrc   = ntSrc_t'(quadCode[quad]);
    strb.vidRead  = vidRd;
    strb.vidWrite = vidWr;
    strb.cpuRead  = cpuRd;
    strb.cpuExRd  = cpuExHit;
    strb.cpuExWr  = cpuWr && cpuExHit;
    // CPU write owns the single extended RAM write port
    strb.vidExWr  = vidWr && inWin && (strb.vidSrc == SRC_EXRAM)
                    && (exMode < EX_WRITE_LIMIT) && !strb.cpuExWr;
  end

  assign fillTile = fillTileQ;
  assign fillAttr = fillAttrQ;

  // R8: registers come out of reset at their defined values
  assert_reset_values_R8: assert property (@(posedge clk)
    $past(rst) |-> (mapReg == MAP_RESET && exMode == '0 &&
                    fillTileQ == '0 && fillAttrQ == '0));

  // R6: map register changes only through its own address
  assert_map_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(cpuWr && cpuAddr == CADDR_W'(REG_MAP)) |=> $stable(mapReg));

  // R6: fill attribute keeps the low bits of the written byte
  assert_attr_write_R6: assert property (@(posedge clk) disable iff (rst)
    (cpuWr && cpuAddr == CADDR_W'(REG_ATTR)) |=> fillAttr == $past(cpuWrData[ATTR_W-1:0]));

  // R4: blocked mode never lets a video write reach extended RAM
  assert_mode_block_R4: assert property (@(posedge clk) disable iff (rst)
    (exMode >= EX_WRITE_LIMIT) |-> !strb.vidExWr);

endmodule

// File: rtl/ntsel_dpath.sv
module ntsel_dpath
  import nt_route_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  ntStrobe_t         strb,
  input  logic [OFF_W-1:0]  cpuOff,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [OFF_W-1:0]  vidOff,
  input  logic [DATA_W-1:0] vidWrData,
  input  logic [DATA_W-1:0] fillTile,
  input  logic [DATA_W-1:0] ntRdData,
  output logic [OFF_W:0]    ntAddr,
  output logic              ntRe,
  output logic              ntWe,
  output logic [DATA_W-1:0] ntWrData,
  output logic [DATA_W-1:0] vidRdData,
  output logic [DATA_W-1:0] cpuRdData
);

  localparam int EX_DEPTH = 1 << OFF_W;

  logic [DATA_W-1:0] exMem [EX_DEPTH];
  logic [DATA_W-1:0] auxQ;      // extended RAM byte or fill tile
  logic [DATA_W-1:0] cpuMemQ;
  ntSrc_t            srcQ;
  logic              hitQ;
  logic              cpuHitQ;
  logic              pageSrc;

  assign pageSrc = !strb.vidSrc[1];

  // external nametable RAM side
  assign ntAddr   = {strb.vidSrc[0], vidOff};
  assign ntRe     = strb.vidRead  && strb.vidHit && pageSrc;
  assign ntWe     = strb.vidWrite && strb.vidHit && pageSrc;
  assign ntWrData = vidWrData;

  // extended RAM: one write port, two read ports, read-before-write
  always_ff @(posedge clk) begin
    if (strb.cpuExWr)      exMem[cpuOff] <= cpuWrData;
    else if (strb.vidExWr) exMem[vidOff] <= vidWrData;
  end

  always_ff @(posedge clk) begin
    if (strb.vidRead)
      auxQ <= (strb.vidSrc == SRC_FILL) ? fillTile : exMem[vidOff];
    if (strb.cpuRead)
      cpuMemQ <= exMem[cpuOff];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srcQ    <= SRC_PAGE0;
      hitQ    <= 1'b0;
      cpuHitQ <= 1'b0;
    end else begin
      if (strb.vidRead) begin
        srcQ <= strb.vidSrc;
        hitQ <= strb.vidHit;
      end
      if (strb.cpuRead) cpuHitQ <= strb.cpuExRd;
    end
  end

  always_comb begin
    if (!hitQ)            vidRdData = '0;
    else if (!srcQ[1])    vidRdData = ntRdData;
    else                  vidRdData = auxQ;
  end

  assign cpuRdData = cpuHitQ ? cpuMemQ : '0;

  // R7: CPU write lands in extended RAM next cycle
  assert_cpu_ex_write_R7: assert property (@(posedge clk) disable iff (rst)
    strb.cpuExWr |=> exMem[$past(cpuOff)] == $past(cpuWrData));

  // R4: accepted video write lands in extended RAM next cycle
  assert_vid_ex_write_R4: assert property (@(posedge clk) disable iff (rst)
    strb.vidExWr |=> exMem[$past(vidOff)] == $past(vidWrData));

  // R5: fill quadrant read returns the fill tile of the read cycle
  assert_fill_read_R5: assert property (@(posedge clk) disable iff (rst)
    (strb.vidRead && strb.vidHit && strb.vidSrc == SRC_FILL)
      |=> vidRdData == $past(fillTile));

  // R2: one video access never drives two memories
  assert_single_target_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ntWe, ntRe, strb.vidExWr}));

  // R9: CPU write and video write never share the write port
  assert_port_owner_R9: assert property (@(posedge clk) disable iff (rst)
    !(strb.cpuExWr && strb.vidExWr));

endmodule

// File: rtl/nametable_router.sv
module nametable_router
  import nt_route_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OFF_W   = 10,
  parameter int VADDR_W = 14,
  parameter int CADDR_W = 16,
  parameter int ATTR_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpuWr,
  input  logic               cpuRd,
  input  logic [CADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0]  cpuWrData,
  output logic [DATA_W-1:0]  cpuRdData,
  input  logic               vidRd,
  input  logic               vidWr,
  input  logic [VADDR_W-1:0] vidAddr,
  input  logic [DATA_W-1:0]  vidWrData,
  output logic [DATA_W-1:0]  vidRdData,
  output logic [OFF_W:0]     ntAddr,
  output logic               ntRe,
  output logic               ntWe,
  output logic [DATA_W-1:0]  ntWrData,
  input  logic [DATA_W-1:0]  ntRdData,
  output logic [ATTR_W-1:0]  fillAttr
);

  ntStrobe_t         strb;
  logic [DATA_W-1:0] fillTile;

  ntsel_ctrl #(
    .DATA_W(DATA_W), .OFF_W(OFF_W), .VADDR_W(VADDR_W),
    .CADDR_W(CADDR_W), .ATTR_W(ATTR_W)
  ) i_ctrl (
    .clk(clk), .rst(rst),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .vidRd(vidRd), .vidWr(vidWr), .vidAddr(vidAddr),
    .strb(strb), .fillTile(fillTile), .fillAttr(fillAttr)
  );

  ntsel_dpath #(
    .DATA_W(DATA_W), .OFF_W(OFF_W)
  ) i_dpath (
    .clk(clk), .rst(rst), .strb(strb),
    .cpuOff(cpuAddr[OFF_W-1:0]), .cpuWrData(cpuWrData),
    .vidOff(vidAddr[OFF_W-1:0]), .vidWrData(vidWrData),
    .fillTile(fillTile), .ntRdData(ntRdData),
    .ntAddr(ntAddr), .ntRe(ntRe), .ntWe(ntWe), .ntWrData(ntWrData),
    .vidRdData(vidRdData), .cpuRdData(cpuRdData)
  );

endmodule

// File: tb/test_nametable_router.sv
`timescale 1ns/1ps
module test_nametable_router;

  localparam real HALF = 2.0;          // 250 MHz
  localparam int  WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic        cpuWr, cpuRd;
  logic [15:0] cpuAddr;
  logic [7:0]  cpuWrData, cpuRdData;
  logic        vidRd, vidWr;
  logic [13:0] vidAddr;
  logic [7:0]  vidWrData, vidRdData;
  logic [10:0] ntAddr;
  logic        ntRe, ntWe;
  logic [7:0]  ntWrData, ntRdData;
  logic [1:0]  fillAttr;

  always #(HALF) clk = ~clk;

  nametable_router i_nametable_router (
    .clk(clk), .rst(rst),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuRdData(cpuRdData),
    .vidRd(vidRd), .vidWr(vidWr), .vidAddr(vidAddr), .vidWrData(vidWrData),
    .vidRdData(vidRdData),
    .ntAddr(ntAddr), .ntRe(ntRe), .ntWe(ntWe), .ntWrData(ntWrData),
    .ntRdData(ntRdData), .fillAttr(fillAttr)
  );

  // external nametable RAM (environment, one-cycle read)
  logic [7:0] ntMem [2048];
  always @(posedge clk) begin
    if (ntRe) ntRdData <= ntMem[ntAddr];
    if (ntWe) ntMem[ntAddr] <= ntWrData;
  end

  // behavioural reference model
  logic [7:0] mMap, mFill;
  logic [1:0] mMode, mAttr;
  logic [7:0] mNt [2048];
  logic [7:0] mEx [1024];
  logic [7:0] expVid, expCpu;
  string      vidReq;

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string req, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, tag, act, exp);
    end
  endtask

  // one clock: drive after negedge, check comb outputs, model the edge,
  // check registered outputs at the following negedge
  task automatic step(input logic cw, input logic cr, input logic [15:0] ca,
                      input logic [7:0] cd, input logic vw, input logic vr,
                      input logic [13:0] va, input logic [7:0] vd,
                      input string tag);
    logic       inWin, cpuEx;
    logic [1:0] code;
    cpuWr = cw; cpuRd = cr; cpuAddr = ca; cpuWrData = cd;
    vidWr = vw; vidRd = vr; vidAddr = va; vidWrData = vd;
    #1;
    inWin = (va[13:12] == 2'b10);
    code  = mMap[{va[11:10], 1'b0} +: 2];
    cpuEx = (ca[15:10] == 6'h17);
    check(ntRe === (vr && inWin && !code[1]), "R2", tag, 32'(ntRe), 32'(vr && inWin && !code[1]));
    check(ntWe === (vw && inWin && !code[1]), "R2", tag, 32'(ntWe), 32'(vw && inWin && !code[1]));
    if (ntRe || ntWe)
      check(ntAddr === {code[0], va[9:0]}, "R1", tag, 32'(ntAddr), 32'({code[0], va[9:0]}));
    if (ntWe)
      check(ntWrData === vd, "R2", tag, 32'(ntWrData), 32'(vd));
    if (vr) begin
      if (!inWin) begin
        expVid = 8'h00; vidReq = "R10";
      end else begin
        case (code)
          2'd0: begin expVid = mNt[{1'b0, va[9:0]}]; vidReq = "R2"; end
          2'd1: begin expVid = mNt[{1'b1, va[9:0]}]; vidReq = "R2"; end
          2'd2: begin expVid = mEx[va[9:0]];         vidReq = "R3"; end
          default: begin expVid = mFill;             vidReq = "R5"; end
        endcase
      end
    end
    if (cr) expCpu = cpuEx ? mEx[ca[9:0]] : 8'h00;
    if (vw && inWin && !code[1]) mNt[{code[0], va[9:0]}] = vd;
    if (cw && cpuEx) mEx[ca[9:0]] = cd;
    else if (vw && inWin && code == 2'd2 && mMode < 2'd2) mEx[va[9:0]] = vd;
    if (cw) begin
      case (ca)
        16'h5104: mMode = cd[1:0];
        16'h5105: mMap  = cd;
        16'h5106: mFill = cd;
        16'h5107: mAttr = cd[1:0];
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check(vidRdData === expVid, vidReq, tag, 32'(vidRdData), 32'(expVid));
    check(cpuRdData === expCpu, "R7", tag, 32'(cpuRdData), 32'(expCpu));
    check(fillAttr === mAttr, "R6", tag, 32'(fillAttr), 32'(mAttr));
  endtask

  task automatic cpuW(input logic [15:0] a, input logic [7:0] d, input string tag);
    step(1'b1, 1'b0, a, d, 1'b0, 1'b0, 14'h0, 8'h0, tag);
  endtask
  task automatic cpuR(input logic [15:0] a, input string tag);
    step(1'b0, 1'b1, a, 8'h0, 1'b0, 1'b0, 14'h0, 8'h0, tag);
  endtask
  task automatic vidW(input logic [13:0] a, input logic [7:0] d, input string tag);
    step(1'b0, 1'b0, 16'h0, 8'h0, 1'b1, 1'b0, a, d, tag);
  endtask
  task automatic vidR(input logic [13:0] a, input string tag);
    step(1'b0, 1'b0, 16'h0, 8'h0, 1'b0, 1'b1, a, 8'h0, tag);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) begin ntMem[i] = 8'h00; mNt[i] = 8'h00; end
    for (int i = 0; i < 1024; i++) mEx[i] = 8'h00;
    mMap = 8'h44; mFill = 8'h00; mMode = 2'd0; mAttr = 2'd0;
    expVid = 8'h00; expCpu = 8'h00; vidReq = "R8";
    ntRdData = 8'h00;
    rst = 1'b1;
    cpuWr = 0; cpuRd = 0; cpuAddr = 0; cpuWrData = 0;
    vidWr = 0; vidRd = 0; vidAddr = 0; vidWrData = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R8: reset state visible at the ports
    check(fillAttr === 2'd0, "R8", "reset attr", 32'(fillAttr), 0);
    check(cpuRdData === 8'h00, "R8", "reset cpu data", 32'(cpuRdData), 0);
    check(vidRdData === 8'h00, "R8", "reset vid data", 32'(vidRdData), 0);
    cpuR(16'h5105, "R8 map register reads as 0 on CPU port");

    // fill extended RAM with known bytes
    for (int i = 0; i < 1024; i++)
      cpuW(16'(16'h5C00 + i), 8'(i) ^ 8'h3C, "R7 ex fill");

    // R8: vertical mirroring after reset
    vidW(14'h2005, 8'h11, "R8 q0 page0");
    vidW(14'h2406, 8'h22, "R8 q1 page1");
    vidR(14'h2805, "R8 q2 aliases page0");
    vidR(14'h2C06, "R8 q3 aliases page1");
    vidR(14'h2C06, "R10 hold"); step(0,0,16'h0,8'h0,0,0,14'h0,8'h0,"R10 hold idle");

    // map: q0 page0, q1 page1, q2 ex, q3 fill
    cpuW(16'h5105, 8'hE4, "R6 map write");
    cpuW(16'h5106, 8'hA5, "R6 fill write");
    cpuW(16'h5107, 8'hFF, "R6 attr keeps two bits");
    cpuW(16'h5108, 8'h00, "R6 unused address ignored");
    vidR(14'h2810, "R3 ex read");
    vidW(14'h2810, 8'h5A, "R4 ex write mode 0");
    cpuR(16'h5C10, "R4 ex write landed");
    vidR(14'h2810, "R3 ex read back");

    // R4: mode 2 blocks video writes
    cpuW(16'h5104, 8'h02, "R4 mode 2");
    vidW(14'h2811, 8'h77, "R4 blocked write");
    cpuR(16'h5C11, "R4 blocked write not stored");
    cpuW(16'h5104, 8'h01, "R4 mode 1");
    vidW(14'h2811, 8'h78, "R4 mode 1 write");
    cpuR(16'h5C11, "R4 mode 1 stored");

    // R5: fill quadrant
    vidW(14'h2C05, 8'h99, "R5 fill write discarded");
    vidR(14'h2C05, "R5 fill read");
    step(1'b1, 1'b0, 16'h5106, 8'h3E, 1'b0, 1'b1, 14'h2C00, 8'h0, "R5 fill old value");
    vidR(14'h2C01, "R5 fill new value");

    // R9: collisions
    cpuW(16'h5C20, 8'h11, "R9 setup");
    step(1'b1, 1'b0, 16'h5C20, 8'h22, 1'b0, 1'b1, 14'h2820, 8'h0, "R9 read sees old");
    vidR(14'h2820, "R9 read sees new");
    step(1'b1, 1'b0, 16'h5C30, 8'h44, 1'b1, 1'b0, 14'h2831, 8'h55, "R9 video write dropped");
    cpuR(16'h5C30, "R9 cpu write kept");
    cpuR(16'h5C31, "R9 video target unchanged");

    // R10 / R1: outside the window
    vidR(14'h3000, "R10 out of window read");
    vidW(14'h0400, 8'hEE, "R1 out of window write");
    vidR(14'h1C00, "R10 out of window read 2");

    // R1/R2: page mapping swap (horizontal)
    cpuW(16'h5105, 8'h50, "R1 horizontal map");
    vidR(14'h2405, "R1 q1 page0");
    vidR(14'h2806, "R1 q2 page1");

    // long mixed run
    void'($urandom(32'h1D2E));
    for (int i = 0; i < 3000; i++) begin
      logic        cw, cr, vw, vr;
      logic [15:0] ca;
      logic [13:0] va;
      int          pick;
      cw = 0; cr = 0; vw = 0; vr = 0;
      pick = int'($urandom % 4);
      if (pick == 1) cw = 1; else if (pick == 2) cr = 1;
      pick = int'($urandom % 3);
      if (pick == 1) vw = 1; else if (pick == 2) vr = 1;
      case ($urandom % 8)
        0: ca = 16'h5104;
        1: ca = 16'h5105;
        2: ca = 16'h5106;
        3: ca = 16'h5107;
        4: ca = 16'h5200;
        default: ca = 16'(16'h5C00 + ($urandom % 1024));
      endcase
      va = 14'($urandom);
      if ($urandom % 5 != 0) va[13:12] = 2'b10;
      step(cw, cr, ca, 8'($urandom), vw, vr, va, 8'($urandom), "R9 R10 mixed run");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule